// File: doc/BRIEF.md
# Interruptible DDR Write Burst Transmitter

This block is the controller-side transmit path for a single burst write to a mobile DDR memory. Once it accepts a write request, it sequences eight data beats at two beats per clock. It presents each clock's pair of beats on a rising-half bus and a falling-half bus, together with an active-high byte mask for each beat, a data output enable, a strobe output enable and a strobe-run flag. The pad logic turns the strobe-run flag into a toggling strobe. The strobe is driven low for one preamble cycle before the first beat and one postamble cycle after the last beat, and it is released to high impedance outside a burst.

Write data arrives one beat pair per clock through a valid/ready handshake. A pair is taken in the cycle before it appears on the pins. A one-cycle interrupt input (a precharge to the same bank, or a new column command) can cut the burst short. From that point on no more data is taken, and every beat pair not yet loaded goes out with all mask bits set and zero data. The strobe keeps running through the full four-cycle burst slot so that the memory still captures the mask state. If data is missing when the block asks for it, that pair is masked in the same way.

A pulse marks the input-clock cycle that follows the strobe edge carrying the last valid beat of a run, so that a bank timing tracker can start counting write recovery. A new request is taken only after the postamble has ended.

Top module: `wbt_burst_tx`

## Requirements
- R1: After reset, dq_oe, dqs_oe, dqs_run and wr_last are low, wd_ready is low and req_ready is high.
- R2: When a request is accepted (req_valid and req_ready high at a clock edge), the next cycle is a preamble: dqs_oe high, dqs_run low, dq_oe low.
- R3: The four cycles after the preamble are data cycles with dq_oe high. wd_ready is high in the preamble cycle and in the first three data cycles. Pair p, taken with the handshake in the cycle before it appears, is shown in data cycle p: wd_data[15:0] (beat 2p) on dq_rise and wd_data[31:16] (beat 2p+1) on dq_fall.
- R4: For a pair that was taken, wd_mask[1:0] appears on dm_rise and wd_mask[3:2] on dm_fall. Bit 0 of each field belongs to the lane dq[7:0], and a 1 masks the byte.
- R5: If cut is high in a preamble or data cycle, wd_ready is low in that cycle and in every later cycle of the burst. Each pair whose handshake cycle falls at or after the cut cycle is sent with dm_rise and dm_fall all ones and zero data. A cut in the cycle that offers pair p therefore masks beats 2p through 7.
- R6: dqs_run is high in every data cycle, masked or not, and low in every other cycle.
- R7: If wd_valid is low while wd_ready is high, the pair is not taken and goes out with all mask bits set and zero data.
- R8: Exactly one postamble cycle follows the last data cycle (dqs_oe high, dqs_run low, dq_oe low). In the next cycle all outputs are released, and req_ready is high only in that released state.
- R9: wr_last is high for one cycle, in the cycle after a data cycle that carried taken data, whenever that next cycle carries none. A burst with no taken data gives no pulse.
- R10: cut has no effect while the block is idle or in the postamble. A burst that follows either case sends all its data unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Burst write request |
| req_ready | output | 1 | Block is idle and accepts a request |
| wd_valid | input | 1 | Write data pair present |
| wd_ready | output | 1 | Block takes a data pair this cycle |
| wd_data | input | 32 | Beat pair: [15:0] even beat, [31:16] odd beat |
| wd_mask | input | 4 | Byte masks: [1:0] even beat, [3:2] odd beat |
| cut | input | 1 | Burst interrupt (precharge or new column command) |
| dq_rise | output | 16 | Data for the rising-strobe half |
| dq_fall | output | 16 | Data for the falling-strobe half |
| dm_rise | output | 2 | Byte mask for the rising-half beat |
| dm_fall | output | 2 | Byte mask for the falling-half beat |
| dq_oe | output | 1 | Data and mask output enable |
| dqs_oe | output | 1 | Strobe output enable (low means high impedance) |
| dqs_run | output | 1 | Strobe toggles this cycle (low drives it low) |
| wr_last | output | 1 | Cycle after the last valid beat of a run |

## Verification
The bench cuts the burst in the preamble, in the first, second and last data cycles, and in the postamble and idle cycles. A design that masked from the wrong beat would be off by one pair. A design that stopped the strobe at the cut would leave dqs_run low in masked cycles. A design that kept a stale cut would mask the next burst. A missing pair in mid-burst checks that underrun masks only that pair and that the recovery pulse fires at each end of a valid run. A fully masked burst checks that it fires no pulse. Back-to-back requests held high check that the next burst starts only one cycle after the postamble, and that req_ready never rises mid-burst.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PRE  = 2'd1,
      PH_DATA = 2'd2,
      PH_POST = 2'd3
   } wbt_phase_e;
endpackage

// File: rtl/wbt_seq.sv
module wbt_seq
   import wbt_pkg::*;
#(
   parameter int PAIRS    = 4,
   parameter int PRE_CYC  = 1,
   parameter int POST_CYC = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       cut,
   input  logic       wd_valid,
   output logic       req_ready,
   output logic       wd_ready,
   output logic       load_slot,
   output logic       take,
   output wbt_phase_e ph_next,
   output logic       last_pulse
);
   localparam int MAX_AB = (PAIRS > PRE_CYC) ? PAIRS : PRE_CYC;
   localparam int MAXC   = (MAX_AB > POST_CYC) ? MAX_AB : POST_CYC;
   localparam int CW     = $clog2(MAXC) + 1;
   localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);
   localparam logic [CW-1:0] PAIR_LAST = CW'(PAIRS - 1);
   localparam logic [CW-1:0] POST_LAST = CW'(POST_CYC - 1);

   wbt_phase_e    ph_q;
   logic [CW-1:0] cnt_q, cnt_n;
   logic          cut_q, cut_now, burst_live;
   logic          has_q, pulse_q;

   // phase sequencer: idle -> preamble -> data pairs -> postamble -> idle
   always_comb begin
      ph_next = ph_q;
      cnt_n   = cnt_q;
      unique case (ph_q)
         PH_IDLE: begin
            if (req_valid) begin
               ph_next = PH_PRE;
               cnt_n   = '0;
            end
         end
         PH_PRE: begin
            if (cnt_q == PRE_LAST) begin
               ph_next = PH_DATA;
               cnt_n   = '0;
            end else begin
               cnt_n = cnt_q + CW'(1);
            end
         end
         PH_DATA: begin
            if (cnt_q == PAIR_LAST) begin
               ph_next = PH_POST;
               cnt_n   = '0;
            end else begin
               cnt_n = cnt_q + CW'(1);
            end
         end
         PH_POST: begin
            if (cnt_q == POST_LAST) begin
               ph_next = PH_IDLE;
               cnt_n   = '0;
            end else begin
               cnt_n = cnt_q + CW'(1);
            end
         end
         default: begin
            ph_next = PH_IDLE;
            cnt_n   = '0;
         end
      endcase
   end

   assign req_ready  = (ph_q == PH_IDLE);
   assign burst_live = (ph_q == PH_PRE) || (ph_q == PH_DATA);
   assign cut_now    = cut_q | (cut & burst_live);
   assign load_slot  = (ph_next == PH_DATA);
   assign wd_ready   = load_slot & ~cut_now;
   assign take       = wd_ready & wd_valid;
   assign last_pulse = pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         cnt_q   <= '0;
         cut_q   <= 1'b0;
         has_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         ph_q    <= ph_next;
         cnt_q   <= cnt_n;
         cut_q   <= (ph_q == PH_IDLE) ? 1'b0 : cut_now;
         has_q   <= take;
         pulse_q <= has_q & ~take;
      end
   end
endmodule

// File: rtl/wbt_lane.sv
module wbt_lane #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_slot,
   input  logic              take,
   input  logic [LANE_W-1:0] d_r,
   input  logic [LANE_W-1:0] d_f,
   input  logic              m_r,
   input  logic              m_f,
   output logic [LANE_W-1:0] q_r,
   output logic [LANE_W-1:0] q_f,
   output logic              dm_r,
   output logic              dm_f
);
   // a slot without taken data is sent as zero with the mask set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r  <= '0;
         q_f  <= '0;
         dm_r <= 1'b0;
         dm_f <= 1'b0;
      end else if (load_slot) begin
         q_r  <= take ? d_r : '0;
         q_f  <= take ? d_f : '0;
         dm_r <= take ? m_r : 1'b1;
         dm_f <= take ? m_f : 1'b1;
      end else begin
         q_r  <= '0;
         q_f  <= '0;
         dm_r <= 1'b0;
         dm_f <= 1'b0;
      end
   end
endmodule

// File: rtl/wbt_strobe.sv
module wbt_strobe
   import wbt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  wbt_phase_e ph_next,
   output logic       dqs_oe,
   output logic       dqs_run,
   output logic       dq_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dqs_oe  <= 1'b0;
         dqs_run <= 1'b0;
         dq_oe   <= 1'b0;
      end else begin
         dqs_oe  <= (ph_next != PH_IDLE);
         dqs_run <= (ph_next == PH_DATA);
         dq_oe   <= (ph_next == PH_DATA);
      end
   end
endmodule

// File: rtl/wbt_burst_tx.sv
module wbt_burst_tx
   import wbt_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int LANE_W    = 8,
   parameter int BURST_LEN = 8,
   parameter int PRE_CYC   = 1,
   parameter int POST_CYC  = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    wd_valid,
   output logic                    wd_ready,
   input  logic [2*LANES*LANE_W-1:0] wd_data,
   input  logic [2*LANES-1:0]      wd_mask,
   input  logic                    cut,
   output logic [LANES*LANE_W-1:0] dq_rise,
   output logic [LANES*LANE_W-1:0] dq_fall,
   output logic [LANES-1:0]        dm_rise,
   output logic [LANES-1:0]        dm_fall,
   output logic                    dq_oe,
   output logic                    dqs_oe,
   output logic                    dqs_run,
   output logic                    wr_last
);
   localparam int DW    = LANES * LANE_W;
   localparam int PAIRS = BURST_LEN / 2;

   if (BURST_LEN < 2 || (BURST_LEN % 2) != 0) begin : g_bad_len
      $error("BURST_LEN must be even and at least 2");
   end
   if (PRE_CYC < 1 || POST_CYC < 1) begin : g_bad_amble
      $error("preamble and postamble need at least one cycle");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end

   wbt_phase_e ph_next;
   logic       load_slot, take;

   wbt_seq #(
      .PAIRS   (PAIRS),
      .PRE_CYC (PRE_CYC),
      .POST_CYC(POST_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .cut       (cut),
      .wd_valid  (wd_valid),
      .req_ready (req_ready),
      .wd_ready  (wd_ready),
      .load_slot (load_slot),
      .take      (take),
      .ph_next   (ph_next),
      .last_pulse(wr_last)
   );

   wbt_strobe u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .ph_next(ph_next),
      .dqs_oe (dqs_oe),
      .dqs_run(dqs_run),
      .dq_oe  (dq_oe)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      wbt_lane #(.LANE_W(LANE_W)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_slot(load_slot),
         .take     (take),
         .d_r      (wd_data[g*LANE_W +: LANE_W]),
         .d_f      (wd_data[DW + g*LANE_W +: LANE_W]),
         .m_r      (wd_mask[g]),
         .m_f      (wd_mask[LANES + g]),
         .q_r      (dq_rise[g*LANE_W +: LANE_W]),
         .q_f      (dq_fall[g*LANE_W +: LANE_W]),
         .dm_r     (dm_rise[g]),
         .dm_f     (dm_fall[g])
      );
   end
endmodule

// File: rtl/wbt_burst_tx_chk.sv
module wbt_burst_tx_chk #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_ready,
   input logic                    wd_ready,
   input logic                    cut,
   input logic [LANES*LANE_W-1:0] dq_rise,
   input logic [LANES*LANE_W-1:0] dq_fall,
   input logic [LANES-1:0]        dm_rise,
   input logic [LANES-1:0]        dm_fall,
   input logic                    dq_oe,
   input logic                    dqs_oe,
   input logic                    dqs_run,
   input logic                    wr_last
);
   p_preamble_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dqs_oe) |-> (!dq_oe && !dqs_run));

   p_ready_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wd_ready |-> (dqs_oe && !req_ready));

   p_no_take_after_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cut && dqs_oe) |=> !wd_ready);

   p_mask_after_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cut && dqs_oe) |=> (!dq_oe || ((&dm_rise) && (&dm_fall)
                                      && dq_rise == '0 && dq_fall == '0)));

   p_strobe_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (dqs_run && dqs_oe));

   p_postamble_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_oe) |-> (dqs_oe && !dqs_run));

   p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!dqs_oe && !dq_oe));

   p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_last |=> !wr_last);

   p_pulse_after_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_last |-> $past(dq_oe));
endmodule

bind wbt_burst_tx wbt_burst_tx_chk #(
   .LANES (LANES),
   .LANE_W(LANE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .wd_ready (wd_ready),
   .cut      (cut),
   .dq_rise  (dq_rise),
   .dq_fall  (dq_fall),
   .dm_rise  (dm_rise),
   .dm_fall  (dm_fall),
   .dq_oe    (dq_oe),
   .dqs_oe   (dqs_oe),
   .dqs_run  (dqs_run),
   .wr_last  (wr_last)
);

// File: tb/test_wbt_burst_tx.sv
module test_wbt_burst_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        wd_valid = 1'b0;
   logic        wd_ready;
   logic [31:0] wd_data = '0;
   logic [3:0]  wd_mask = '0;
   logic        cut = 1'b0;
   logic [15:0] dq_rise, dq_fall;
   logic [1:0]  dm_rise, dm_fall;
   logic        dq_oe, dqs_oe, dqs_run, wr_last;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   wbt_burst_tx i_wbt_burst_tx (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data), .wd_mask(wd_mask),
      .cut(cut), .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise),
      .dm_fall(dm_fall), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_run(dqs_run),
      .wr_last(wr_last)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dpat(input logic [31:0] seed, input int p);
      return seed + 32'h0101_0101 * 32'(p + 1);
   endfunction

   function automatic logic [3:0] mpat(input logic [31:0] seed, input int p);
      return seed[3:0] + 4'(p);
   endfunction

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 dq_oe", 32'(dq_oe), 0);
      chk("R1 dqs_oe", 32'(dqs_oe), 0);
      chk("R1 dqs_run", 32'(dqs_run), 0);
      chk("R1 wr_last", 32'(wr_last), 0);
      chk("R1 wd_ready", 32'(wd_ready), 0);
      chk("R1 req_ready", 32'(req_ready), 1);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
   endtask

   // c: cycle of the cut pulse (0 = idle request cycle, 1 = preamble,
   //    2..5 = data cycles, 6 = postamble, -1 = none); ur: pair left without data
   task automatic run_burst(input string name, input int c, input int ur,
                            input bit hold, input logic [31:0] seed);
      bit masked [4];
      bit vld [8];
      for (int q = 0; q < 4; q++)
         masked[q] = (c >= 1 && c <= q + 1) || (q == ur);
      for (int t = 0; t < 8; t++)
         vld[t] = (t >= 2 && t <= 5) ? !masked[t-2] : 1'b0;

      req_valid = 1'b1;
      cut       = (c == 0);
      wd_valid  = 1'b0;
      #1;
      chk({name, " R8 req_ready before start"}, 32'(req_ready), 1);
      @(posedge clk);
      #1;
      for (int t = 1; t <= 7; t++) begin
         int p = t - 1;
         req_valid = hold;
         cut       = (c == t);
         wd_valid  = (t <= 4) && (p != ur);
         wd_data   = dpat(seed, p);
         wd_mask   = mpat(seed, p);
         #1;
         chk({name, " R3 R5 wd_ready"}, 32'(wd_ready),
             32'((t <= 4) && !(c >= 1 && c <= t)));
         chk({name, " R8 req_ready"}, 32'(req_ready), 32'(t == 7));
         chk({name, " R2 R8 dqs_oe"}, 32'(dqs_oe), 32'(t <= 6));
         chk({name, " R2 R8 dq_oe"}, 32'(dq_oe), 32'(t >= 2 && t <= 5));
         chk({name, " R6 dqs_run"}, 32'(dqs_run), 32'(t >= 2 && t <= 5));
         if (t >= 2 && t <= 5) begin
            int q = t - 2;
            logic [31:0] d = dpat(seed, q);
            if (masked[q]) begin
               chk({name, " R5 R7 dq masked zero"}, {dq_fall, dq_rise}, 32'h0);
               chk({name, " R5 R7 dm all set"}, 32'({dm_fall, dm_rise}), 32'hF);
            end else begin
               chk({name, " R3 dq pair"}, {dq_fall, dq_rise}, d);
               chk({name, " R4 dm pair"}, 32'({dm_fall, dm_rise}), 32'(mpat(seed, q)));
            end
         end
         chk({name, " R9 wr_last"}, 32'(wr_last), 32'(vld[t-1] && !vld[t]));
         if (t < 7) begin
            @(posedge clk);
            #1;
         end
      end
      cut = 1'b0;
      wd_valid = 1'b0;
   endtask

   initial begin
      t_reset();
      run_burst("full", -1, -1, 1'b0, 32'hA5C3_0F10);
      run_burst("cut at beat 4", 3, -1, 1'b0, 32'h1234_5672);
      run_burst("cut in preamble", 1, -1, 1'b0, 32'h0BAD_F00D);
      run_burst("cut at beat 2", 2, -1, 1'b0, 32'h7777_0003);
      run_burst("cut at beat 6", 4, -1, 1'b0, 32'h5A5A_A5A4);
      run_burst("cut in last data cycle", 5, -1, 1'b0, 32'h2222_1115);
      run_burst("underrun pair 1", -1, 1, 1'b0, 32'h3C3C_0006);
      run_burst("R10 cut while idle", 0, -1, 1'b0, 32'hFACE_0007);
      run_burst("R10 cut in postamble", 6, -1, 1'b1, 32'h0F0F_1238);
      run_burst("back to back", -1, -1, 1'b0, 32'hDEAD_BEE9);
      run_burst("underrun last pair", -1, 3, 1'b0, 32'h4444_000A);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule